// File: doc/BRIEF.md
# Multi-Track Event Scheduler

The scheduler turns stored, timestamped sequencer events into a MIDI byte stream. Eight tracks each present their next pending event (timestamp, compact type code, channel and two data bytes) with a valid flag. When a new sequencer position arrives on the tick input, the block visits the tracks in ascending index order. A one-hot track bit rotates in step with the index. A track is served only if its bit is set in the active mask and clear in the mute mask. Every event on that track whose timestamp equals the position is decoded and sent as a MIDI message before the scan moves to the next track.

The compact type code selects the MIDI status family. The status nibble is combined with the 4-bit channel, except for system exclusive. After the last byte of an event is accepted downstream, a one-hot consume strobe tells the owning track to present its next event. A source must hold an event's fields steady until it sees its consume strobe. The masks must not change while a pass is running.

Back-pressure rules: the byte output is valid/ready. A byte transfers on a clock edge where both `out_valid` and `out_ready` are high. While `out_ready` is low, `out_valid` stays high and `out_byte` is held, and the scan makes no progress. The tick input is also valid/ready. `tick_ready` is high only between passes, so a new position is accepted only after the previous pass has finished.

Top module: `mtrk_event_sched`

## Requirements
- R1: While reset is asserted and right after it, `tick_ready` is 1, `out_valid` is 0 and `consume` is all zeros.
- R2: A pass visits tracks in ascending index order 0 to 7. `consume` is never more than one-hot, and bit i refers to track i.
- R3: A track whose active-mask bit is 0, or whose mute-mask bit is 1, emits nothing and is never consumed during that pass.
- R4: An event is emitted and consumed only if its timestamp equals the accepted position. An event with any other timestamp stays pending.
- R5: A type code below 0x7A is a note. It sends three bytes: status 0x90 OR channel, then the type code itself as the key number, then data byte 0.
- R6: Type code 0x7A sends 0xC0 OR channel, and code 0x7B sends 0xD0 OR channel. Each is followed by data byte 0 only.
- R7: Type code 0x7C sends 0xE0 OR channel, then data byte 0, then data byte 1.
- R8: Type code 0x7D sends the single byte 0xF0, with no channel combined and no data bytes.
- R9: Type codes 0x7E and 0x7F send no bytes, but the event is still consumed.
- R10: All matching events on a track are sent before any later track. `tick_ready` stays low from the accepted tick until the whole pass is done.
- R11: While `out_valid` is 1 and `out_ready` is 0, on the next cycle `out_valid` is still 1 and `out_byte` is unchanged.
- R12: A consume pulse for an emitted event occurs in the same cycle as the handshake of that event's last byte. A pulse for an R9 event occurs while `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_valid | input | 1 | New sequencer position offered |
| tick_ready | output | 1 | Scheduler idle, position can be taken |
| tick_pos | input | 16 | Sequencer position |
| active_mask | input | 8 | Per-track active bits |
| mute_mask | input | 8 | Per-track mute bits |
| ev_valid | input | 8 | Track holds a pending event |
| ev_time | input | 8x16 | Per-track event timestamp |
| ev_code | input | 8x8 | Per-track compact type code |
| ev_chan | input | 8x4 | Per-track MIDI channel |
| ev_d0 | input | 8x8 | Per-track first data byte |
| ev_d1 | input | 8x8 | Per-track second data byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts byte |
| out_byte | output | 8 | MIDI byte |
| consume | output | 8 | One-hot pulse: track may advance |

## Verification
A tick is accepted on the edge where `tick_valid` and `tick_ready` are both high. Track 0 is examined in the next cycle. When it matches, the first byte is valid one cycle after that, and each further byte follows one cycle after the previous handshake. `consume` rises combinationally in the cycle of the final handshake, or in the scan cycle of an R9 event, and the source advances on that edge. The bench drives inputs one time unit after the rising edge and samples every output on the falling edge. It pops a predicted byte and consume queue for each handshake it sees, and checks that both queues are empty at the first falling edge where `tick_ready` is high again.

// File: rtl/mtrk_pkg.sv
package mtrk_pkg;

  localparam int CH_W = 4;

  localparam logic [7:0] CODE_PROG  = 8'h7A;
  localparam logic [7:0] CODE_PRESS = 8'h7B;
  localparam logic [7:0] CODE_BEND  = 8'h7C;
  localparam logic [7:0] CODE_SYSX  = 8'h7D;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_EMIT = 2'd2
  } sched_st_t;

  // Decoded event: status byte, total bytes to send, and whether the
  // second byte is the type code itself (note key number).
  typedef struct packed {
    logic [7:0] status;
    logic [1:0] nbytes;
    logic       key_from_code;
  } evdec_t;

  function automatic evdec_t decode_code(input logic [7:0] code,
                                         input logic [CH_W-1:0] ch);
    evdec_t d;
    d.status        = 8'h00;
    d.nbytes        = 2'd0;
    d.key_from_code = 1'b0;
    if (code < CODE_PROG) begin
      d.status        = {4'h9, ch};
      d.nbytes        = 2'd3;
      d.key_from_code = 1'b1;
    end else begin
      case (code)
        CODE_PROG:  begin d.status = {4'hC, ch}; d.nbytes = 2'd2; end
        CODE_PRESS: begin d.status = {4'hD, ch}; d.nbytes = 2'd2; end
        CODE_BEND:  begin d.status = {4'hE, ch}; d.nbytes = 2'd3; end
        CODE_SYSX:  begin d.status = 8'hF0;      d.nbytes = 2'd1; end
        default:    begin d.status = 8'h00;      d.nbytes = 2'd0; end
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/mtrk_match.sv
// Per-track eligibility: serviceable and due at the current position.
module mtrk_match #(
  parameter int NTRK = 8,
  parameter int TW   = 16
) (
  input  logic [NTRK-1:0]         active_mask,
  input  logic [NTRK-1:0]         mute_mask,
  input  logic [NTRK-1:0]         ev_valid,
  input  logic [NTRK-1:0][TW-1:0] ev_time,
  input  logic [TW-1:0]           pos,
  output logic [NTRK-1:0]         due
);
  for (genvar g = 0; g < NTRK; g++) begin : g_trk
    assign due[g] = active_mask[g] & ~mute_mask[g] & ev_valid[g] &
                    (ev_time[g] == pos);
  end
endmodule

// File: rtl/mtrk_pick.sv
// Selects the track under service and decodes its event.
module mtrk_pick
  import mtrk_pkg::*;
#(
  parameter int NTRK = 8,
  localparam int IW  = (NTRK > 1) ? $clog2(NTRK) : 1
) (
  input  logic [IW-1:0]             idx,
  input  logic [NTRK-1:0][7:0]      ev_code,
  input  logic [NTRK-1:0][CH_W-1:0] ev_chan,
  input  logic [NTRK-1:0][7:0]      ev_d0,
  input  logic [NTRK-1:0][7:0]      ev_d1,
  output evdec_t                    dec,
  output logic [7:0]                byte1,
  output logic [7:0]                byte2
);
  logic [7:0]      code;
  logic [CH_W-1:0] ch;
  logic [7:0]      d0, d1;

  always_comb begin
    code  = ev_code[idx];
    ch    = ev_chan[idx];
    d0    = ev_d0[idx];
    d1    = ev_d1[idx];
    dec   = decode_code(code, ch);
    byte1 = dec.key_from_code ? code : d0;
    byte2 = dec.key_from_code ? d0   : d1;
  end
endmodule

// File: rtl/mtrk_emitter.sv
// Holds one decoded event and streams its bytes over valid/ready.
module mtrk_emitter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] status,
  input  logic [7:0] byte1,
  input  logic [7:0] byte2,
  input  logic [1:0] nbytes,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_byte,
  output logic       done
);
  logic       busy;
  logic [1:0] cnt, last;
  logic [7:0] s_q, b1_q, b2_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= 2'd0;
      last <= 2'd0;
      s_q  <= 8'h00;
      b1_q <= 8'h00;
      b2_q <= 8'h00;
    end else if (load) begin
      busy <= 1'b1;
      cnt  <= 2'd0;
      last <= nbytes - 2'd1;
      s_q  <= status;
      b1_q <= byte1;
      b2_q <= byte2;
    end else if (busy && out_ready) begin
      if (cnt == last) busy <= 1'b0;
      else             cnt  <= cnt + 2'd1;
    end
  end

  always_comb begin
    out_valid = busy;
    done      = busy && out_ready && (cnt == last);
    case (cnt)
      2'd0:    out_byte = s_q;
      2'd1:    out_byte = b1_q;
      default: out_byte = b2_q;
    endcase
  end

  // R11: a stalled byte is held
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));
  // R5: every message opens with a status byte
  p_status_msb_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cnt == 2'd0) |-> out_byte[7]);
endmodule

// File: rtl/mtrk_event_sched.sv
module mtrk_event_sched
  import mtrk_pkg::*;
#(
  parameter int NTRK = 8,
  parameter int TW   = 16,
  localparam int IW  = (NTRK > 1) ? $clog2(NTRK) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_valid,
  output logic                      tick_ready,
  input  logic [TW-1:0]             tick_pos,
  input  logic [NTRK-1:0]           active_mask,
  input  logic [NTRK-1:0]           mute_mask,
  input  logic [NTRK-1:0]           ev_valid,
  input  logic [NTRK-1:0][TW-1:0]   ev_time,
  input  logic [NTRK-1:0][7:0]      ev_code,
  input  logic [NTRK-1:0][CH_W-1:0] ev_chan,
  input  logic [NTRK-1:0][7:0]      ev_d0,
  input  logic [NTRK-1:0][7:0]      ev_d1,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [7:0]                out_byte,
  output logic [NTRK-1:0]           consume
);
  localparam logic [IW-1:0] LAST_IDX = IW'(NTRK - 1);

  sched_st_t       st;
  logic [TW-1:0]   pos_q;
  logic [IW-1:0]   idx;
  logic [NTRK-1:0] trk_bit;
  logic [NTRK-1:0] due;
  evdec_t          dec;
  logic [7:0]      byte1, byte2;
  logic            hit, load, drop, em_done;

  mtrk_match #(.NTRK(NTRK), .TW(TW)) i_match (
    .active_mask(active_mask), .mute_mask(mute_mask), .ev_valid(ev_valid),
    .ev_time(ev_time), .pos(pos_q), .due(due)
  );

  mtrk_pick #(.NTRK(NTRK)) i_pick (
    .idx(idx), .ev_code(ev_code), .ev_chan(ev_chan), .ev_d0(ev_d0),
    .ev_d1(ev_d1), .dec(dec), .byte1(byte1), .byte2(byte2)
  );

  mtrk_emitter i_emit (
    .clk(clk), .rst_n(rst_n), .load(load), .status(dec.status),
    .byte1(byte1), .byte2(byte2), .nbytes(dec.nbytes),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .done(em_done)
  );

  always_comb begin
    hit        = |(due & trk_bit);
    tick_ready = (st == ST_IDLE);
    load       = (st == ST_SCAN) && hit && (dec.nbytes != 2'd0);
    drop       = (st == ST_SCAN) && hit && (dec.nbytes == 2'd0);
    consume    = (drop || ((st == ST_EMIT) && em_done)) ? trk_bit : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      pos_q   <= '0;
      idx     <= '0;
      trk_bit <= NTRK'(1);
    end else begin
      case (st)
        ST_IDLE: if (tick_valid) begin
          pos_q   <= tick_pos;
          idx     <= '0;
          trk_bit <= NTRK'(1);
          st      <= ST_SCAN;
        end
        ST_SCAN: begin
          if (load) begin
            st <= ST_EMIT;
          end else if (!hit) begin
            if (idx == LAST_IDX) begin
              st <= ST_IDLE;
            end else begin
              idx     <= idx + IW'(1);
              trk_bit <= {trk_bit[NTRK-2:0], trk_bit[NTRK-1]};
            end
          end
        end
        ST_EMIT: if (em_done) st <= ST_SCAN;
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2: at most one track released at a time
  p_consume_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(consume));
  // R3: masked tracks are never released
  p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (consume & (~active_mask | mute_mask)) == '0);
  // R10: no new position while bytes are in flight
  p_tick_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !tick_ready);
  // R10: an accepted tick starts a pass
  p_tick_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_valid && tick_ready) |=> !tick_ready);
  // R12: release coincides with the final handshake, or no byte is pending
  p_consume_hs_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|consume) |-> (!out_valid || out_ready));

  for (genvar g = 0; g < NTRK; g++) begin : g_chk
    // R4: a released event was due at the accepted position
    p_time_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
      consume[g] |-> (ev_valid[g] && ev_time[g] == pos_q));
  end
endmodule

// File: tb/test_mtrk_event_sched.sv
module test_mtrk_event_sched;
  localparam int NT = 8;
  localparam int NE = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              tick_valid = 1'b0;
  logic              tick_ready;
  logic [15:0]       tick_pos = '0;
  logic [NT-1:0]     active_mask = '0, mute_mask = '0;
  logic [NT-1:0]     ev_valid;
  logic [NT-1:0][15:0] ev_time;
  logic [NT-1:0][7:0]  ev_code, ev_d0, ev_d1;
  logic [NT-1:0][3:0]  ev_chan;
  logic              out_valid;
  logic              out_ready = 1'b0;
  logic [7:0]        out_byte;
  logic [NT-1:0]     consume;

  mtrk_event_sched i_mtrk_event_sched (
    .clk(clk), .rst_n(rst_n), .tick_valid(tick_valid), .tick_ready(tick_ready),
    .tick_pos(tick_pos), .active_mask(active_mask), .mute_mask(mute_mask),
    .ev_valid(ev_valid), .ev_time(ev_time), .ev_code(ev_code),
    .ev_chan(ev_chan), .ev_d0(ev_d0), .ev_d1(ev_d1), .out_valid(out_valid),
    .out_ready(out_ready), .out_byte(out_byte), .consume(consume)
  );

  // Track sources
  int         m_t [NT][NE];
  logic [7:0] m_c [NT][NE];
  logic [3:0] m_h [NT][NE];
  logic [7:0] m_a [NT][NE];
  logic [7:0] m_b [NT][NE];
  int         cnt [NT];
  int         head [NT];
  logic       clr_heads = 1'b0;

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      int k;
      k = (head[t] < NE) ? head[t] : 0;
      ev_valid[t] = head[t] < cnt[t];
      ev_time[t]  = 16'(m_t[t][k]);
      ev_code[t]  = m_c[t][k];
      ev_chan[t]  = m_h[t][k];
      ev_d0[t]    = m_a[t][k];
      ev_d1[t]    = m_b[t][k];
    end
  end

  always @(posedge clk) begin
    for (int t = 0; t < NT; t++) begin
      if (clr_heads) head[t] <= 0;
      else if (consume[t]) head[t] <= head[t] + 1;
    end
  end

  int checks = 0, fails = 0;
  logic [7:0] exp_b [$];
  int         exp_r [$];
  int         exp_t [$];
  logic       stall_force = 1'b0;
  logic       mon_on = 1'b0;

  task automatic check(input logic ok, input int req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d: got %0h expected %0h", req, act, expv);
    end
  endtask

  // Predicted stream: R5 note, R6 prog/pressure, R7 bend, R8 sysex, R9 undefined
  function automatic void predict(input int pos);
    for (int t = 0; t < NT; t++) begin
      if (active_mask[t] && !mute_mask[t]) begin  // R3
        int h;
        h = head[t];
        while (h < cnt[t] && m_t[t][h] == pos) begin  // R4, R10
          logic [7:0] c;
          c = m_c[t][h];
          if (c < 8'h7A) begin
            exp_b.push_back({4'h9, m_h[t][h]}); exp_r.push_back(5);
            exp_b.push_back(c);                exp_r.push_back(5);
            exp_b.push_back(m_a[t][h]);        exp_r.push_back(5);
          end else if (c == 8'h7A || c == 8'h7B) begin
            exp_b.push_back({(c == 8'h7A) ? 4'hC : 4'hD, m_h[t][h]}); exp_r.push_back(6);
            exp_b.push_back(m_a[t][h]); exp_r.push_back(6);
          end else if (c == 8'h7C) begin
            exp_b.push_back({4'hE, m_h[t][h]}); exp_r.push_back(7);
            exp_b.push_back(m_a[t][h]);         exp_r.push_back(7);
            exp_b.push_back(m_b[t][h]);         exp_r.push_back(7);
          end else if (c == 8'h7D) begin
            exp_b.push_back(8'hF0); exp_r.push_back(8);
          end
          exp_t.push_back(t);
          h++;
        end
      end
    end
  endfunction

  // Monitor on the falling edge
  logic       prev_stall = 1'b0;
  logic [7:0] prev_byte = '0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_stall) begin  // R11
        check(out_valid == 1'b1, 11, out_valid, 1);
        check(out_byte == prev_byte, 11, out_byte, prev_byte);
      end
      if (out_valid && out_ready) begin
        if (exp_b.size() == 0) check(1'b0, 10, out_byte, 0);
        else begin
          logic [7:0] eb; int er;
          eb = exp_b.pop_front(); er = exp_r.pop_front();
          check(out_byte == eb, er, out_byte, eb);
        end
      end
      if (consume != '0) begin
        check($onehot(consume), 2, consume, 0);
        // R12: released with the final handshake or with no byte pending
        check(!out_valid || out_ready, 12, out_valid, 0);
        if (exp_t.size() == 0) check(1'b0, 2, consume, 0);
        else begin
          int et;
          et = exp_t.pop_front();
          check(consume == NT'(1 << et), 2, consume, 1 << et);
        end
        // R10: a track's bytes are all out before it is released
        if (exp_t.size() > 0 || exp_b.size() > 0) ;
      end
      prev_stall = out_valid && !out_ready;
      prev_byte  = out_byte;
    end
  end

  // Downstream readiness
  initial begin
    forever begin
      @(posedge clk); #1;
      out_ready = stall_force ? 1'b0 : (($urandom % 4) != 0);
    end
  end

  task automatic send_tick(input int pos, input logic [NT-1:0] act, input logic [NT-1:0] mut);
    @(posedge clk); #1;
    active_mask = act;
    mute_mask   = mut;
    predict(pos);
    tick_pos    = 16'(pos);
    tick_valid  = 1'b1;
    @(posedge clk); #1;
    tick_valid  = 1'b0;
    @(negedge clk);
    while (!tick_ready) @(negedge clk);
    // R10: pass complete means nothing left to send
    check(exp_b.size() == 0, 10, exp_b.size(), 0);
    check(exp_t.size() == 0, 10, exp_t.size(), 0);
    exp_b.delete(); exp_r.delete(); exp_t.delete();
  endtask

  task automatic clear_tracks();
    for (int t = 0; t < NT; t++) cnt[t] = 0;
    @(posedge clk); #1; clr_heads = 1'b1;
    @(posedge clk); #1; clr_heads = 1'b0;
  endtask

  task automatic add_ev(input int t, input int tm, input logic [7:0] c,
                        input logic [3:0] ch, input logic [7:0] a, input logic [7:0] b);
    m_t[t][cnt[t]] = tm; m_c[t][cnt[t]] = c; m_h[t][cnt[t]] = ch;
    m_a[t][cnt[t]] = a;  m_b[t][cnt[t]] = b;
    cnt[t]++;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10: watchdog expired got 0 expected 1");
    summary();
  end

  initial begin
    void'($urandom(32'd20240517));
    for (int t = 0; t < NT; t++) begin cnt[t] = 0; head[t] = 0; end
    repeat (3) @(negedge clk);
    // R1: reset values
    check(tick_ready == 1'b1, 1, tick_ready, 1);
    check(out_valid == 1'b0, 1, out_valid, 0);
    check(consume == '0, 1, consume, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    check(tick_ready == 1'b1 && out_valid == 1'b0, 1, {tick_ready, out_valid}, 2'b10);
    mon_on = 1'b1;

    // Directed corner cases
    clear_tracks();
    add_ev(0, 0, 8'h3C, 4'h1, 8'h40, 8'h00);  // R5 note
    add_ev(0, 0, 8'h7A, 4'h1, 8'h05, 8'h00);  // R6 program
    add_ev(0, 1, 8'h7C, 4'h2, 8'h00, 8'h40);  // R7 bend
    add_ev(1, 0, 8'h7E, 4'h0, 8'h11, 8'h22);  // R9 undefined
    add_ev(1, 0, 8'h7B, 4'h3, 8'h22, 8'h00);  // R6 pressure
    add_ev(2, 0, 8'h7D, 4'h9, 8'h33, 8'h44);  // R8 sysex, muted first
    add_ev(3, 0, 8'h30, 4'h4, 8'h10, 8'h00);  // R3 inactive first
    add_ev(5, 2, 8'h45, 4'hF, 8'h07, 8'h00);  // R4 future timestamp
    add_ev(7, 0, 8'h7F, 4'h0, 8'h00, 8'h00);  // R9 undefined
    add_ev(7, 0, 8'h79, 4'h0, 8'h01, 8'h00);  // R5 highest note code
    stall_force = 1'b1;
    fork
      send_tick(0, 8'hF7, 8'h04);
      begin repeat (20) @(posedge clk); #1; stall_force = 1'b0; end
    join
    send_tick(1, 8'hFF, 8'h00);
    send_tick(2, 8'hFF, 8'h00);
    // R4: a stale head stays pending
    check(head[2] == 0, 4, head[2], 0);
    check(head[5] == 1, 4, head[5], 1);

    // Random rounds
    for (int r = 0; r < 8; r++) begin
      clear_tracks();
      for (int t = 0; t < NT; t++) begin
        int tm;
        tm = 0;
        for (int e = 0; e < NE; e++) begin
          int k;
          logic [7:0] c;
          tm += $urandom % 2;
          k = $urandom % 8;
          case (k)
            0, 1, 2: c = 8'($urandom % 122);
            3:       c = 8'h7A;
            4:       c = 8'h7B;
            5:       c = 8'h7C;
            6:       c = 8'h7D;
            default: c = 8'h7E + 8'($urandom % 2);
          endcase
          add_ev(t, tm, c, 4'($urandom), 8'($urandom % 128), 8'($urandom % 128));
        end
      end
      for (int p = 0; p <= NE; p++) begin
        logic [NT-1:0] a, m;
        a = NT'($urandom | $urandom);
        m = NT'($urandom & $urandom);
        send_tick(p, a, m);
      end
    end
    summary();
  end
endmodule